// File: doc/BRIEF.md
# SPI NAND Command Phase Sequencer

This block is the host-side engine that carries out a single SPI NAND transaction described by a descriptor. The descriptor names an opcode, how many address bytes follow (zero to three), how many dummy clocks come next, whether a data phase reads or writes, how many data bytes it moves, and how many IO lanes the address and data phases use. The engine owns chip select, the serial clock and four IO lines, and it walks the phases in a fixed order: opcode, address, dummy, data. A phase with zero length is skipped.

Write data is pulled from the requester one byte at a time through a ready/valid pair. The serial clock stops while the engine waits for a byte. Read data is handed back as one byte per single-cycle valid pulse. The serial clock runs at half the system clock in SPI mode 0. A new descriptor is taken only while the engine is idle. Typical uses are a plain opcode such as reset or write enable, an erase or page fetch with a three-byte row address, cache reads on one, two or four lanes, and cache loads on one or four lanes.

Top module: `snq_engine`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io_oe is 0, busy is 0 and done is 0.
- R2: The opcode goes out as 8 bits, MSB first, on IO0 only, one bit per sck period of two clk cycles. sck idles low. A bit is driven while sck is low and holds still while sck is high (mode 0).
- R3: The address phase sends the low `addr_bytes` bytes of `addr`, most significant byte and bit first. It uses the lane width that `addr_lanes` selects.
- R4: The dummy phase lasts exactly `dummy_cycles` sck periods, and io_oe is 0 throughout.
- R5: In a write, each data byte is requested with tx_ready and taken in the cycle where tx_valid and tx_ready are both 1. sck stays low while tx_ready waits. The bytes go out MSB first on the data lane width.
- R6: In a read, io_oe is 0 and io_in is sampled in the clk cycle in which sck rises. A single lane reads IO1. Each completed byte appears on rx_data with a one-cycle rx_valid pulse.
- R7: cs_n stays low from the cycle after an accepted start until the end of the transaction. done is a single-cycle pulse in the cycle in which cs_n returns high, and busy is 1 whenever cs_n is 0.
- R8: start is ignored while busy is 1. The running transaction continues unchanged, and no second transaction follows it.
- R9: A phase with zero length is skipped. A descriptor with no address, no dummy and no data gives exactly 8 sck periods.
- R10: Lane code 0 selects one lane, 1 selects two and 2 selects four, and code 3 is treated as one lane. Driving one lane sets io_oe to 0001 and uses IO0. Two lanes set io_oe to 0011, with IO1 carrying the higher bit of each pair. Four lanes set io_oe to 1111, with IO3 down to IO0 carrying a nibble from high to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the descriptor (only when idle) |
| opcode | input | 8 | Command byte |
| addr | input | 24 | Address, right-aligned |
| addr_bytes | input | 2 | Number of address bytes, 0 to 3 |
| addr_lanes | input | 2 | Lane code of the address phase |
| dummy_cycles | input | DUM_W | Dummy length in sck periods |
| data_dir | input | 1 | 1 = read data in, 0 = write data out |
| data_lanes | input | 2 | Lane code of the data phase |
| data_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| tx_data | input | 8 | Write byte from the requester |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Engine waits for a write byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle received-byte strobe |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | IO line output values |
| io_oe | output | 4 | IO line output enables |
| io_in | input | 4 | IO line input values |

## Verification
The bench targets lane mapping on mixed descriptors: a quad-IO read with a two-byte address on four lanes, and a dual-IO read. A design that swapped lanes or kept the address on IO0 would show a different edge count or wrong bits at the recorded sck rising edges. Dummy lengths of 2, 4 and 8 are checked edge by edge, so an off-by-one in the dummy counter would show up as a shifted read byte and a wrong edge total. A write with a delayed tx_valid would expose a design that keeps clocking while it waits. A start issued mid-transaction would reveal a design that restarts or queues a second frame, through a changed stream or an extra done.

// File: rtl/snq_pkg.sv
package snq_pkg;

    localparam int OP_W      = 8;
    localparam int ADDR_MAXB = 3;
    localparam int SR_W      = 8 * ADDR_MAXB;
    localparam int IO_W      = 4;
    localparam int BIT_W     = $clog2(SR_W + 1);

    typedef logic [1:0] lane_code_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_FETCH,
        PH_FIN
    } phase_t;

    typedef struct packed {
        logic [OP_W-1:0] opcode;
        logic [SR_W-1:0] addr;
        logic [1:0]      addr_bytes;
        lane_code_t      addr_lanes;
        logic            data_dir;
        lane_code_t      data_lanes;
    } desc_t;

    // Bits moved per sck period for a lane code.
    function automatic logic [BIT_W-1:0] lane_bits(lane_code_t c);
        case (c)
            2'd1:    return BIT_W'(2);
            2'd2:    return BIT_W'(4);
            default: return BIT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/snq_lane_out.sv
module snq_lane_out
    import snq_pkg::*;
(
    input  logic [IO_W-1:0] sr_top,
    input  lane_code_t      lanes,
    input  logic            drive,
    output logic [IO_W-1:0] io_out,
    output logic [IO_W-1:0] io_oe
);
    always_comb begin
        io_out = '0;
        io_oe  = '0;
        if (drive) begin
            case (lanes)
                2'd1: begin
                    io_out = {2'b00, sr_top[3:2]};
                    io_oe  = 4'b0011;
                end
                2'd2: begin
                    io_out = sr_top;
                    io_oe  = 4'b1111;
                end
                default: begin
                    io_out = {3'b000, sr_top[3]};
                    io_oe  = 4'b0001;
                end
            endcase
        end
    end
endmodule

// File: rtl/snq_lane_in.sv
module snq_lane_in
    import snq_pkg::*;
(
    input  logic [IO_W-1:0] io_in,
    input  lane_code_t      lanes,
    input  logic [7:0]      shreg,
    output logic [7:0]      shreg_nxt
);
    always_comb begin
        case (lanes)
            2'd1:    shreg_nxt = {shreg[5:0], io_in[1:0]};
            2'd2:    shreg_nxt = {shreg[3:0], io_in};
            default: shreg_nxt = {shreg[6:0], io_in[1]};
        endcase
    end
endmodule

// File: rtl/snq_seq.sv
module snq_seq
    import snq_pkg::*;
#(
    parameter int DUM_W = 5,
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  desc_t             desc,
    input  logic [DUM_W-1:0]  dummy_cycles,
    input  logic [LEN_W-1:0]  data_len,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    input  logic [7:0]        rx_nxt,
    output logic [7:0]        rx_shreg,
    output lane_code_t        cur_lanes,
    output logic              drive,
    output phase_t            phase,
    output logic              sck,
    output logic [IO_W-1:0]   sr_top,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              done
);
    localparam logic [DUM_W-1:0] DUM_ONE = DUM_W'(1);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [BIT_W-1:0] BYTE_BITS = BIT_W'(8);

    phase_t           ph_q;
    logic             sck_q;
    logic [SR_W-1:0]  sr_q;
    logic [BIT_W-1:0] bits_q;
    logic [DUM_W-1:0] dum_q;
    logic [LEN_W-1:0] len_q;
    desc_t            d_q;
    logic [7:0]       rxs_q;
    logic [7:0]       rxd_q;
    logic             rxv_q;
    logic             done_q;

    phase_t           after_dummy, after_addr, after_cmd, leave_to;
    logic [BIT_W-1:0] cur_w;
    logic [SR_W-1:0]  addr_al;

    // Phase order: opcode, address, dummy, data; empty phases are skipped.
    always_comb begin
        if (len_q != '0)
            after_dummy = d_q.data_dir ? PH_DATA : PH_FETCH;
        else
            after_dummy = PH_FIN;
        after_addr = (dum_q != '0) ? PH_DUMMY : after_dummy;
        after_cmd  = (d_q.addr_bytes != 2'd0) ? PH_ADDR : after_addr;
        leave_to   = (ph_q == PH_CMD) ? after_cmd : after_addr;
    end

    always_comb begin
        case (ph_q)
            PH_ADDR: cur_lanes = d_q.addr_lanes;
            PH_DATA: cur_lanes = d_q.data_lanes;
            default: cur_lanes = 2'd0;
        endcase
        cur_w   = lane_bits(cur_lanes);
        addr_al = d_q.addr << (SR_W - 8 * int'(d_q.addr_bytes));
        drive   = (ph_q == PH_CMD) || (ph_q == PH_ADDR) ||
                  ((ph_q == PH_DATA) && !d_q.data_dir);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            sck_q  <= 1'b0;
            sr_q   <= '0;
            bits_q <= '0;
            dum_q  <= '0;
            len_q  <= '0;
            d_q    <= '0;
            rxs_q  <= '0;
            rxd_q  <= '0;
            rxv_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            rxv_q  <= 1'b0;
            done_q <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        d_q    <= desc;
                        dum_q  <= dummy_cycles;
                        len_q  <= data_len;
                        sr_q   <= {desc.opcode, {(SR_W-OP_W){1'b0}}};
                        bits_q <= BIT_W'(OP_W);
                        sck_q  <= 1'b0;
                        ph_q   <= PH_CMD;
                    end
                end
                PH_FETCH: begin
                    if (tx_valid) begin
                        sr_q[SR_W-1 -: 8] <= tx_data;
                        bits_q            <= BYTE_BITS;
                        ph_q              <= PH_DATA;
                    end
                end
                PH_FIN: begin
                    ph_q   <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: begin
                    if (!sck_q) begin
                        // rising edge: sample the input lanes on a read
                        sck_q <= 1'b1;
                        if (ph_q == PH_DATA && d_q.data_dir)
                            rxs_q <= rx_nxt;
                    end else begin
                        // falling edge: advance to the next bit group
                        sck_q <= 1'b0;
                        if (ph_q == PH_DUMMY) begin
                            dum_q <= dum_q - DUM_ONE;
                            if (dum_q == DUM_ONE) begin
                                ph_q <= after_dummy;
                                if (after_dummy == PH_DATA)
                                    bits_q <= BYTE_BITS;
                            end
                        end else begin
                            sr_q   <= sr_q << cur_w;
                            bits_q <= bits_q - cur_w;
                            if (bits_q == cur_w) begin
                                if (ph_q == PH_DATA) begin
                                    if (d_q.data_dir) begin
                                        rxd_q <= rxs_q;
                                        rxv_q <= 1'b1;
                                    end
                                    len_q <= len_q - LEN_ONE;
                                    if (len_q == LEN_ONE)
                                        ph_q <= PH_FIN;
                                    else if (d_q.data_dir)
                                        bits_q <= BYTE_BITS;
                                    else
                                        ph_q <= PH_FETCH;
                                end else begin
                                    ph_q <= leave_to;
                                    if (leave_to == PH_ADDR) begin
                                        sr_q   <= addr_al;
                                        bits_q <= BIT_W'({d_q.addr_bytes, 3'b000});
                                    end else if (leave_to == PH_DATA) begin
                                        bits_q <= BYTE_BITS;
                                    end
                                end
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign phase    = ph_q;
    assign sck      = sck_q;
    assign sr_top   = sr_q[SR_W-1 -: IO_W];
    assign rx_shreg = rxs_q;
    assign rx_data  = rxd_q;
    assign rx_valid = rxv_q;
    assign done     = done_q;

endmodule

// File: rtl/snq_engine.sv
module snq_engine
    import snq_pkg::*;
#(
    parameter int DUM_W = 5,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [23:0]      addr,
    input  logic [1:0]       addr_bytes,
    input  logic [1:0]       addr_lanes,
    input  logic [DUM_W-1:0] dummy_cycles,
    input  logic             data_dir,
    input  logic [1:0]       data_lanes,
    input  logic [LEN_W-1:0] data_len,
    output logic             busy,
    output logic             done,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             cs_n,
    output logic             sck,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    desc_t           desc;
    phase_t          phase;
    lane_code_t      cur_lanes;
    logic            drive;
    logic [IO_W-1:0] sr_top;
    logic [7:0]      rx_shreg;
    logic [7:0]      rx_nxt;

    always_comb begin
        desc.opcode     = opcode;
        desc.addr       = addr;
        desc.addr_bytes = addr_bytes;
        desc.addr_lanes = addr_lanes;
        desc.data_dir   = data_dir;
        desc.data_lanes = data_lanes;
    end

    snq_seq #(.DUM_W(DUM_W), .LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .desc         (desc),
        .dummy_cycles (dummy_cycles),
        .data_len     (data_len),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .rx_nxt       (rx_nxt),
        .rx_shreg     (rx_shreg),
        .cur_lanes    (cur_lanes),
        .drive        (drive),
        .phase        (phase),
        .sck          (sck),
        .sr_top       (sr_top),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .done         (done)
    );

    snq_lane_out u_out (
        .sr_top (sr_top),
        .lanes  (cur_lanes),
        .drive  (drive),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    snq_lane_in u_in (
        .io_in     (io_in),
        .lanes     (cur_lanes),
        .shreg     (rx_shreg),
        .shreg_nxt (rx_nxt)
    );

    assign cs_n     = (phase == PH_IDLE);
    assign busy     = (phase != PH_IDLE);
    assign tx_ready = (phase == PH_FETCH);

endmodule

// File: rtl/snq_engine_chk.sv
module snq_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       cs_n,
    input logic       sck,
    input logic [3:0] io_out,
    input logic [3:0] io_oe
);
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck); // R2

    AST_IO_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        sck |-> ($stable(io_out) && $stable(io_oe))); // R2

    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (io_oe == 4'b0000)); // R1

    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && $past(!cs_n))); // R7

    AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy); // R7

    AST_WAIT_HOLDS_SCK: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (!sck && busy)); // R5

    AST_RX_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (!cs_n && io_oe == 4'b0000)); // R6

    AST_OE_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (io_oe == 4'b0000 || io_oe == 4'b0001 ||
         io_oe == 4'b0011 || io_oe == 4'b1111)); // R10
endmodule

bind snq_engine snq_engine_chk u_chk (.*);

// File: tb/tb_snq_engine.sv
module tb_snq_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DUM_W = 5;
    localparam int LEN_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] opcode = '0;
    logic [23:0] addr = '0;
    logic [1:0] addr_bytes = '0, addr_lanes = '0, data_lanes = '0;
    logic [DUM_W-1:0] dummy_cycles = '0;
    logic data_dir = 1'b0;
    logic [LEN_W-1:0] data_len = '0;
    logic busy, done, tx_ready, rx_valid, cs_n, sck;
    logic [7:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic [7:0] rx_data;
    logic [3:0] io_out, io_oe, io_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    snq_engine #(.DUM_W(DUM_W), .LEN_W(LEN_W)) dut (.*);

    int checks = 0, fails = 0;
    int n_edge = 0, rx_n = 0, done_n = 0, cs_bad = 0, stall_bad = 0;
    logic [3:0] rec_out [256];
    logic [3:0] rec_oe  [256];
    logic [7:0] rx_got  [16];
    logic [7:0] tx_arr  [16];
    int tx_idx = 0, tx_gap = 0, tx_wait = 0;
    bit pend = 0;
    logic sck_prev = 1'b0;

    function automatic logic [3:0] pat(int k);
        return 4'((k * 7 + 3) ^ (k >> 1));
    endfunction

    assign io_in = pat(n_edge);

    function automatic int lw(logic [1:0] c);
        return (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 1;
    endfunction

    function automatic logic [3:0] oe_of(int w);
        return (w == 2) ? 4'b0011 : (w == 4) ? 4'b1111 : 4'b0001;
    endfunction

    function automatic logic [3:0] take(logic [23:0] v, int w);
        return (w == 2) ? {2'b00, v[23:22]} : (w == 4) ? v[23:20] : {3'b000, v[23]};
    endfunction

    // Observer and write-byte source, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!cs_n && sck && !sck_prev) begin
                if (n_edge < 256) begin
                    rec_out[n_edge] = io_out;
                    rec_oe[n_edge]  = io_oe;
                end
                n_edge++;
            end
            if (rx_valid) begin
                if (rx_n < 16) rx_got[rx_n] = rx_data;
                rx_n++;
            end
            if (done) done_n++;
            if (busy && cs_n) cs_bad++;
            if (tx_ready && sck) stall_bad++;
            if (pend) begin
                tx_idx++;
                tx_wait = 0;
            end else if (tx_ready) begin
                tx_wait++;
            end
            tx_valid = (tx_wait >= tx_gap);
            tx_data  = tx_arr[tx_idx % 16];
            pend     = tx_ready && tx_valid;
        end
        sck_prev = sck;
    end

    task automatic chk(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && sck == 1'b0 && io_oe == 4'b0 && !busy && !done,
            "R1", "reset state {cs_n,sck,io_oe,busy,done}",
            int'({cs_n, sck, io_oe, busy, done}), int'(9'b1_0_0000_0_0));
    endtask

    task automatic run_txn(string rq, logic [7:0] op, logic [23:0] ad, int ab,
                           logic [1:0] al, int dm, bit dir, logic [1:0] dl,
                           int len, int gap, bit poke);
        logic [3:0] eo [256];
        logic [3:0] ev [256];
        logic [7:0] erx [16];
        logic [23:0] a;
        logic [7:0] b;
        logic [3:0] p;
        int ne, w, bad_i, timeout;

        @(negedge clk);
        n_edge = 0; rx_n = 0; done_n = 0; cs_bad = 0; stall_bad = 0;
        tx_idx = 0; tx_wait = 0; tx_gap = gap;
        opcode = op; addr = ad; addr_bytes = 2'(ab); addr_lanes = al;
        dummy_cycles = DUM_W'(dm); data_dir = dir; data_lanes = dl;
        data_len = LEN_W'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        if (poke) begin
            repeat (20) @(negedge clk);
            opcode = 8'h06; addr_bytes = 2'd0; dummy_cycles = '0; data_len = '0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            opcode = op; addr_bytes = 2'(ab); dummy_cycles = DUM_W'(dm);
            data_len = LEN_W'(len);
        end

        // expected stream
        ne = 0;
        for (int i = 7; i >= 0; i--) begin
            eo[ne] = 4'b0001; ev[ne] = {3'b000, op[i]}; ne++;
        end
        w = lw(al);
        a = ad << (8 * (3 - ab));
        for (int c = 0; c < (8 * ab) / w; c++) begin
            eo[ne] = oe_of(w); ev[ne] = take(a, w); a = a << w; ne++;
        end
        for (int c = 0; c < dm; c++) begin
            eo[ne] = 4'b0000; ev[ne] = 4'b0000; ne++;
        end
        w = lw(dl);
        for (int j = 0; j < len; j++) begin
            a = {tx_arr[j], 16'h0000};
            b = 8'h00;
            for (int c = 0; c < 8 / w; c++) begin
                if (dir) begin
                    p = pat(ne);
                    b = (w == 1) ? {b[6:0], p[1]} : (w == 2) ? {b[5:0], p[1:0]} : {b[3:0], p};
                    eo[ne] = 4'b0000; ev[ne] = 4'b0000;
                end else begin
                    eo[ne] = oe_of(w); ev[ne] = take(a, w); a = a << w;
                end
                ne++;
            end
            erx[j] = b;
        end

        timeout = 0;
        while (done_n == 0 && timeout < 20000) begin
            @(posedge clk);
            timeout++;
        end
        chk(done_n != 0, rq, "transaction completes", done_n, 1);
        repeat (60) @(posedge clk);

        chk(n_edge == ne, rq, "sck rising edge count (R9 when phases skip)", n_edge, ne);
        bad_i = -1;
        for (int k = 0; k < ne && k < n_edge; k++) begin
            if (bad_i < 0 && (rec_oe[k] != eo[k] || (rec_out[k] & eo[k]) != (ev[k] & eo[k])))
                bad_i = k;
        end
        chk(bad_i < 0, rq, "io lines at sck rise (R2/R10 lanes)",
            (bad_i < 0) ? 0 : int'({rec_oe[bad_i], rec_out[bad_i]}),
            (bad_i < 0) ? 0 : int'({eo[bad_i], ev[bad_i]}));
        if (dir) begin
            chk(rx_n == len, "R6", "received byte count", rx_n, len);
            for (int j = 0; j < len && j < rx_n; j++)
                chk(rx_got[j] == erx[j], "R6", "received byte", rx_got[j], erx[j]);
        end else if (len > 0) begin
            chk(tx_idx == len, "R5", "write bytes taken", tx_idx, len);
            chk(stall_bad == 0, "R5", "sck low while waiting for write byte", stall_bad, 0);
        end
        chk(done_n == 1, poke ? "R8" : "R7", "single done pulse", done_n, 1);
        chk(cs_bad == 0, "R7", "cs_n low while busy", cs_bad, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) tx_arr[i] = 8'(i * 37 + 90);
        t_reset();
        // R2: plain reset opcode
        run_txn("R2", 8'hFF, 24'h0, 0, 2'd0, 0, 1'b0, 2'd0, 0, 0, 1'b0);
        // R9: write enable, all optional phases empty
        run_txn("R9", 8'h06, 24'h0, 0, 2'd0, 0, 1'b0, 2'd0, 0, 0, 1'b0);
        // R3: block erase with 3-byte row address
        run_txn("R3", 8'hD8, 24'h01A5C3, 3, 2'd0, 0, 1'b0, 2'd0, 0, 0, 1'b0);
        // R4: read ID with 8 dummy clocks, 4 bytes in
        run_txn("R4", 8'h9F, 24'h0, 0, 2'd0, 8, 1'b1, 2'd0, 4, 0, 1'b0);
        // R10: quad IO read
        run_txn("R10", 8'hEB, 24'h002B7E, 2, 2'd2, 4, 1'b1, 2'd2, 3, 0, 1'b0);
        // R6: dual IO read
        run_txn("R6", 8'hBB, 24'h0013C9, 2, 2'd1, 2, 1'b1, 2'd1, 2, 0, 1'b0);
        // R5: quad cache load with slow requester
        tx_arr[0] = 8'hA5; tx_arr[1] = 8'h3C; tx_arr[2] = 8'hE1;
        run_txn("R5", 8'h32, 24'h000104, 2, 2'd0, 0, 1'b0, 2'd2, 3, 3, 1'b0);
        // R5: single-lane cache load with immediate data
        tx_arr[0] = 8'h81; tx_arr[1] = 8'h7E;
        run_txn("R5", 8'h02, 24'h000FF0, 2, 2'd0, 0, 1'b0, 2'd0, 2, 0, 1'b0);
        // R8: start pulsed mid-transaction
        run_txn("R8", 8'h13, 24'h00A0B1, 3, 2'd0, 0, 1'b0, 2'd0, 0, 0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule